// File: doc/BRIEF.md
# Boundary-Mode PFC Gate Pulse Controller

This block produces the gate drive for a boost power-factor stage that runs at the edge between continuous and discontinuous inductor current. It sees only digitised comparator outputs: two zero-current-detect levels, a current-sense over-limit, the on-time ramp reaching the control level, the ramp reaching its peak, and the feedback overvoltage and undervoltage detectors. It uses these, an enable and the system clock to decide on every clock edge whether the switch is on.

A switching cycle starts when the demagnetisation ring of the inductor is seen. The upper zero-current level must first arm the detector. A later falling crossing of the lower level then fires a start. If no pulse has started for a whole restart period, a pulse starts anyway, so the converter can come up from power-on and keep running at light load. Once a pulse is on, several conditions end it: the on-time ramp reaching the control level, the ramp reaching its peak, the over-limit input after a short blanking window, overvoltage, undervoltage, or loss of enable. Termination always wins over a start in the same cycle. While the gate is off, the block asks for the timing ramp to be discharged and held low. It also flags the first pulse after each enable.

Top module: `crm_pfc_ctrl`

## Requirements
- R1: During and straight after reset, gate_o is 0, ramp_dis_o is 1 and first_pulse_o is 0.
- R2: After zcd_arm_i has been sampled high on some clock edge, a falling edge of zcd_trig_i starts a pulse. A falling edge means the input is 1 on one edge and 0 on the next. gate_o goes to 1 at the edge where the falling edge is seen.
- R3: A falling edge of zcd_trig_i with no arming since the previous falling edge starts no pulse.
- R4: When no pulse starts and no clear condition holds for WD_CYCLES consecutive edges, a pulse starts on the WD_CYCLES-th edge. The clear conditions are undervoltage and disable.
- R5: While uvp_i is 1, gate_o stays 0 and the restart timer is held at its start value.
- R6: ton_hit_i sampled 1 while the gate is on turns gate_o off at that edge, and ramp_dis_o is 1 whenever gate_o is 0.
- R7: peak_hit_i sampled 1 while the gate is on turns gate_o off at that edge.
- R8: ilim_i has no effect on the first BLANK_CYCLES edges after gate_o rises. At any later edge while the gate is on, it turns gate_o off.
- R9: While ovp_i is 1, no pulse starts and an active pulse ends at the next edge. Once ovp_i clears after a whole restart period, a pulse starts at the next edge.
- R10: A termination condition present in the same cycle as a start request wins, and gate_o stays 0.
- R11: first_pulse_o is 1 for exactly one cycle, during the first gate-on cycle after enable_i goes high, and is 0 on later pulses.
- R12: While enable_i is 0, no pulse starts, and an active pulse ends at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Controller enable |
| zcd_arm_i | input | 1 | Zero-current detector upper (arming) level, 1 when above |
| zcd_trig_i | input | 1 | Zero-current detector lower (trigger) level, 1 when above |
| ilim_i | input | 1 | Current-sense over-limit |
| ton_hit_i | input | 1 | On-time ramp plus offset reached control level |
| peak_hit_i | input | 1 | On-time ramp reached its peak (maximum on-time) |
| ovp_i | input | 1 | Feedback overvoltage |
| uvp_i | input | 1 | Feedback undervoltage |
| gate_o | output | 1 | Gate drive |
| ramp_dis_o | output | 1 | Discharge and hold the on-time ramp |
| first_pulse_o | output | 1 | One-cycle flag on the first pulse after enable |

## Verification
The bench builds the block with WD_CYCLES set to 40 and BLANK_CYCLES set to 4, instead of the defaults of tens of thousands and 28. With these values the exact watchdog restart edge, the watchdog saturating under a long overvoltage, and the last ignored and first honoured over-limit edge can all be reached within a few hundred cycles. Randomised on-time lengths and choices of terminating source are then run over many back-to-back zero-current cycles.

// File: rtl/crm_pfc_pkg.sv
package crm_pfc_pkg;

    typedef struct packed {
        logic ton_hit;
        logic peak_hit;
        logic ilim;
        logic ovp;
        logic uvp;
        logic off;
    } stop_req_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_ZCD  = 2'd1,
        CAUSE_WDOG = 2'd2
    } start_cause_e;

    function automatic logic stop_any(input stop_req_t s, input logic ilim_live);
        return s.ton_hit | s.peak_hit | (s.ilim & ilim_live) | s.ovp | s.uvp | s.off;
    endfunction

    function automatic start_cause_e pick_cause(input logic zcd_hit, input logic wd_hit);
        if (zcd_hit) return CAUSE_ZCD;
        if (wd_hit)  return CAUSE_WDOG;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/pfc_zcd_edge.sv
module pfc_zcd_edge (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic arm_i,
    input  logic trig_i,
    output logic fire_o
);
    logic trig_q;
    logic armed_q;
    logic fall;

    assign fall   = trig_q & ~trig_i;
    assign fire_o = en_i & armed_q & fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            trig_q <= trig_i;
            if (!en_i || fall)
                armed_q <= 1'b0;
            else if (arm_i)
                armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pfc_restart_wd.sv
module pfc_restart_wd #(
    parameter int WD_CYCLES = 45000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    output logic expired_o
);
    localparam int W = $clog2(WD_CYCLES + 1);
    localparam logic [W-1:0] LAST = W'(WD_CYCLES - 1);

    logic [W-1:0] cnt_q;

    assign expired_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (!expired_o)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pfc_gate_latch.sv
module pfc_gate_latch
    import crm_pfc_pkg::*;
#(
    parameter int BLANK_CYCLES = 28
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      set_i,
    input  stop_req_t stop_i,
    output logic      gate_o,
    output logic      set_ok_o
);
    localparam int BW = $clog2(BLANK_CYCLES + 1);
    localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYCLES);

    logic          gate_q;
    logic [BW-1:0] blank_q;
    logic          ilim_live;
    logic          stop;

    assign ilim_live = gate_q & (blank_q == BLANK_END);
    assign stop      = stop_any(stop_i, ilim_live);
    assign set_ok_o  = set_i & ~gate_q & ~stop;
    assign gate_o    = gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= 1'b0;
            blank_q <= '0;
        end else begin
            gate_q <= ~stop & (gate_q | set_i);
            if (set_ok_o)
                blank_q <= '0;
            else if (gate_q && blank_q != BLANK_END)
                blank_q <= blank_q + 1'b1;
        end
    end
endmodule

// File: rtl/crm_pfc_ctrl.sv
module crm_pfc_ctrl
    import crm_pfc_pkg::*;
#(
    parameter int WD_CYCLES    = 45000,
    parameter int BLANK_CYCLES = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic zcd_arm_i,
    input  logic zcd_trig_i,
    input  logic ilim_i,
    input  logic ton_hit_i,
    input  logic peak_hit_i,
    input  logic ovp_i,
    input  logic uvp_i,
    output logic gate_o,
    output logic ramp_dis_o,
    output logic first_pulse_o
);
    logic         zcd_fire;
    logic         wd_expired;
    logic         set_ok;
    logic         start_req;
    start_cause_e cause;
    stop_req_t    stops;
    logic         seen_q;
    logic         first_q;

    pfc_zcd_edge u_zcd (
        .clk    (clk),
        .rst    (rst),
        .en_i   (enable_i),
        .arm_i  (zcd_arm_i),
        .trig_i (zcd_trig_i),
        .fire_o (zcd_fire)
    );

    pfc_restart_wd #(.WD_CYCLES(WD_CYCLES)) u_wd (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (set_ok | uvp_i | ~enable_i),
        .expired_o (wd_expired)
    );

    always_comb begin
        stops.ton_hit  = ton_hit_i;
        stops.peak_hit = peak_hit_i;
        stops.ilim     = ilim_i;
        stops.ovp      = ovp_i;
        stops.uvp      = uvp_i;
        stops.off      = ~enable_i;
        cause          = pick_cause(zcd_fire, wd_expired);
        start_req      = (cause != CAUSE_NONE) & enable_i & ~ovp_i & ~uvp_i;
    end

    pfc_gate_latch #(.BLANK_CYCLES(BLANK_CYCLES)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .set_i    (start_req),
        .stop_i   (stops),
        .gate_o   (gate_o),
        .set_ok_o (set_ok)
    );

    always_ff @(posedge clk) begin
        if (rst || !enable_i) begin
            seen_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            first_q <= set_ok & ~seen_q;
            if (set_ok)
                seen_q <= 1'b1;
        end
    end

    assign ramp_dis_o    = ~gate_o;
    assign first_pulse_o = first_q;
endmodule

// File: rtl/crm_pfc_ctrl_chk.sv
module crm_pfc_ctrl_chk #(
    parameter int BLANK_CYCLES = 28
) (
    input logic clk,
    input logic rst,
    input logic enable_i,
    input logic ilim_i,
    input logic ton_hit_i,
    input logic peak_hit_i,
    input logic ovp_i,
    input logic uvp_i,
    input logic gate_o,
    input logic first_pulse_o
);
    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !gate_o)
            hi_cnt <= 0;
        else if (hi_cnt < 32'(BLANK_CYCLES) + 1)
            hi_cnt <= hi_cnt + 1;
    end

    p_ton_cut_r6: assert property (@(posedge clk) disable iff (rst)
        (gate_o && ton_hit_i) |=> !gate_o);

    p_peak_cut_r7: assert property (@(posedge clk) disable iff (rst)
        (gate_o && peak_hit_i) |=> !gate_o);

    p_blank_cut_r8: assert property (@(posedge clk) disable iff (rst)
        (gate_o && ilim_i && hi_cnt >= 32'(BLANK_CYCLES)) |=> !gate_o);

    p_ovp_cut_r9: assert property (@(posedge clk) disable iff (rst)
        ovp_i |=> !gate_o);

    p_uvp_cut_r5: assert property (@(posedge clk) disable iff (rst)
        uvp_i |=> !gate_o);

    p_off_cut_r12: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !gate_o);

    p_first_gate_r11: assert property (@(posedge clk) disable iff (rst)
        first_pulse_o |-> gate_o);

    p_first_once_r11: assert property (@(posedge clk) disable iff (rst)
        first_pulse_o |=> !first_pulse_o);
endmodule

bind crm_pfc_ctrl crm_pfc_ctrl_chk #(.BLANK_CYCLES(BLANK_CYCLES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable_i      (enable_i),
    .ilim_i        (ilim_i),
    .ton_hit_i     (ton_hit_i),
    .peak_hit_i    (peak_hit_i),
    .ovp_i         (ovp_i),
    .uvp_i         (uvp_i),
    .gate_o        (gate_o),
    .first_pulse_o (first_pulse_o)
);

// File: tb/crm_pfc_ctrl_test.sv
module crm_pfc_ctrl_test;
    localparam int WD    = 40;
    localparam int BLANK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable_i = 1'b0, zcd_arm_i = 1'b0, zcd_trig_i = 1'b0;
    logic ilim_i = 1'b0, ton_hit_i = 1'b0, peak_hit_i = 1'b0;
    logic ovp_i = 1'b0, uvp_i = 1'b0;
    logic gate_o, ramp_dis_o, first_pulse_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    crm_pfc_ctrl #(.WD_CYCLES(WD), .BLANK_CYCLES(BLANK)) uut (
        .clk(clk), .rst(rst), .enable_i(enable_i),
        .zcd_arm_i(zcd_arm_i), .zcd_trig_i(zcd_trig_i),
        .ilim_i(ilim_i), .ton_hit_i(ton_hit_i), .peak_hit_i(peak_hit_i),
        .ovp_i(ovp_i), .uvp_i(uvp_i),
        .gate_o(gate_o), .ramp_dis_o(ramp_dis_o), .first_pulse_o(first_pulse_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // ends at the negedge after the edge that sees the armed falling trigger
    task automatic zcd_fire();
        zcd_arm_i = 1'b1; zcd_trig_i = 1'b1;
        step(1);
        zcd_arm_i = 1'b0; zcd_trig_i = 1'b0;
        step(1);
    endtask

    function automatic int exp_hold_edges(input int src, input int n);
        return (src == 2) ? BLANK : n - 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hold_bad;
        void'($urandom(32'd20240611));
        step(4);
        chk("R1 gate", gate_o, 0);
        chk("R1 ramp_dis", ramp_dis_o, 1);
        chk("R1 first", first_pulse_o, 0);
        rst = 1'b0;
        step(1);
        chk("R1 gate after release", gate_o, 0);

        // R12: disabled, nothing starts
        zcd_fire();
        chk("R12 no start while disabled", gate_o, 0);
        hold_bad = 0;
        for (int i = 0; i < WD + 10; i++) begin step(1); if (gate_o) hold_bad++; end
        chk("R12 idle while disabled", hold_bad, 0);

        // R2/R11/R6
        enable_i = 1'b1;
        zcd_fire();
        chk("R2 zcd start", gate_o, 1);
        chk("R11 first flag", first_pulse_o, 1);
        step(1);
        chk("R11 first flag one cycle", first_pulse_o, 0);
        ton_hit_i = 1'b1; step(1); ton_hit_i = 1'b0;
        chk("R6 ton end", gate_o, 0);
        chk("R6 ramp discharge", ramp_dis_o, 1);

        // R7, first flag absent on second pulse
        zcd_fire();
        chk("R2 second start", gate_o, 1);
        chk("R11 no flag later", first_pulse_o, 0);
        peak_hit_i = 1'b1; step(1); peak_hit_i = 1'b0;
        chk("R7 peak end", gate_o, 0);

        // R3: unarmed falling edge
        zcd_trig_i = 1'b1; step(1);
        zcd_trig_i = 1'b0; step(2);
        chk("R3 unarmed fall", gate_o, 0);

        // R10: start and termination together
        zcd_arm_i = 1'b1; zcd_trig_i = 1'b1; step(1);
        zcd_arm_i = 1'b0; zcd_trig_i = 1'b0; ton_hit_i = 1'b1; step(1);
        chk("R10 stop dominates", gate_o, 0);
        ton_hit_i = 1'b0;

        // R5 / R4
        uvp_i = 1'b1;
        hold_bad = 0;
        for (int i = 0; i < 3 * WD; i++) begin step(1); if (gate_o) hold_bad++; end
        chk("R5 undervoltage holds off", hold_bad, 0);
        uvp_i = 1'b0;
        step(WD - 1);
        chk("R4 watchdog not yet", gate_o, 0);
        step(1);
        chk("R4 watchdog restart edge", gate_o, 1);
        ton_hit_i = 1'b1; step(1); ton_hit_i = 1'b0;

        // R9
        ovp_i = 1'b1;
        zcd_fire();
        chk("R9 zcd suppressed", gate_o, 0);
        hold_bad = 0;
        for (int i = 0; i < WD + 10; i++) begin step(1); if (gate_o) hold_bad++; end
        chk("R9 suppressed during ovp", hold_bad, 0);
        ovp_i = 1'b0; step(1);
        chk("R9 resume after ovp", gate_o, 1);
        ton_hit_i = 1'b1; step(1); ton_hit_i = 1'b0;
        zcd_fire();
        chk("R2 start before ovp", gate_o, 1);
        ovp_i = 1'b1; step(1); ovp_i = 1'b0;
        chk("R9 ovp ends pulse", gate_o, 0);

        // R12 during pulse, R11 re-enable
        zcd_fire();
        enable_i = 1'b0; step(1);
        chk("R12 disable ends pulse", gate_o, 0);
        enable_i = 1'b1;
        zcd_fire();
        chk("R11 flag after re-enable", first_pulse_o, 1);
        ton_hit_i = 1'b1; step(1); ton_hit_i = 1'b0;

        // random cycles
        for (int it = 0; it < 40; it++) begin
            int n, src, hold;
            n    = $urandom_range(1, 10);
            src  = $urandom_range(0, 2);
            hold = exp_hold_edges(src, n);
            step($urandom_range(0, 5));
            zcd_fire();
            chk("R2 random start", gate_o, 1);
            if (src == 2) ilim_i = 1'b1;
            step(hold);
            chk(src == 2 ? "R8 blanked over-limit" : "R6 pulse held", gate_o, 1);
            if (src == 0) ton_hit_i = 1'b1;
            if (src == 1) peak_hit_i = 1'b1;
            step(1);
            chk(src == 2 ? "R8 over-limit end" : (src == 0 ? "R6 random end" : "R7 random end"),
                gate_o, 0);
            ilim_i = 1'b0; ton_hit_i = 1'b0; peak_hit_i = 1'b0;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule